// File: doc/BRIEF.md
# I2C Slave Receiver with Address Match

This block sits behind the sampled SCL and SDA lines of a two-wire bus and acts as the addressed side of a write transfer. It watches for a START condition and shifts in the first byte. It accepts that byte when the upper seven bits equal its own address. It also accepts the all-zero general-call address, but only if the general-call enable bit (bit 0 of the address register) is set. When it accepts, it pulls SDA low during the ninth clock to acknowledge. It then raises an interrupt flag and posts a status code that names the event.

Data bytes that follow are shifted into a receive register and acknowledged or refused according to the acknowledge-enable control bit. Each byte is reported with its own status code, and the code differs between the own-address path and the general-call path. A STOP or repeated START that arrives while the block is receiving is reported with a code of its own.

A master on the same chip can signal that it lost arbitration. If the block is then addressed, it reports separate codes for that entry path. The block does not transmit data when it is addressed for a read. It only acknowledges the address and reports the read status. While a byte event is pending it holds SCL low, so the bus waits until software clears the flag.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset `sda_pull_o`, `scl_hold_o` and `int_flag_o` are 0, `data_rx_o` is 0x00 and `status_o` is 0xF8.
- R2: With enable and acknowledge-enable set and both start and stop control bits clear, a first byte whose bits [7:1] equal `own_addr_i[7:1]` and whose bit 0 (direction) is 0 is acknowledged. SDA is pulled low for the ninth clock, `int_flag_o` is then set and `status_o` reads 0x60.
- R3: A first byte of 0x00 is acknowledged with status 0x70 only when `own_addr_i[0]` is 1. When that bit is 0 the byte is refused and no flag is raised.
- R4: A first byte that matches neither address is refused and raises no flag. Data bytes that follow are then refused until the next START.
- R5: A data byte received after an own-address write is placed in `data_rx_o`. It is acknowledged with status 0x80 when acknowledge-enable is 1. Otherwise it is refused with status 0x88, and every later byte of the transfer is refused without raising the flag.
- R6: A data byte received after a general-call write reports 0x90 when acknowledged and 0x98 when refused.
- R7: After an `arb_lost_i` pulse that follows a START, a matching address reports 0x68 for own address with write, 0x78 for general call, and 0xB0 for own address with read.
- R8: Own address with the read bit set, and no arbitration loss, is acknowledged with status 0xA8.
- R9: A STOP or repeated START that arrives while the block is receiving after an acknowledged write address sets the flag with status 0xA0. A STOP that follows a repeated START raises no flag.
- R10: With enable, or acknowledge-enable, at 0, or with a start or stop control bit at 1, a matching address is refused and no flag is raised.
- R11: Each address or data event sets `scl_hold_o` together with the flag. A pulse on `int_clr_i` clears both. A STOP or START event sets the flag without `scl_hold_o`.
- R12: `sda_pull_o` changes only while SCL is low, so the acknowledge level stays constant for the whole high phase of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled, synchronised SCL line |
| sda_i | input | 1 | Sampled, synchronised SDA line |
| own_addr_i | input | 8 | Own address in [7:1]; general-call enable in [0] |
| ctl_en_i | input | 1 | Interface enable |
| ctl_ack_en_i | input | 1 | Acknowledge enable |
| ctl_sta_i | input | 1 | Start request bit (must be 0 for slave use) |
| ctl_sto_i | input | 1 | Stop request bit (must be 0 for slave use) |
| int_clr_i | input | 1 | One-cycle pulse that clears the interrupt flag |
| arb_lost_i | input | 1 | Pulse from the local master on arbitration loss |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| scl_hold_o | output | 1 | Hold SCL low when 1 |
| int_flag_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code of the last event |
| data_rx_o | output | 8 | Last received data byte |

## Verification
The hardest states to reach are the arbitration-loss entries. They need an `arb_lost_i` pulse to fall between a START and the end of the address byte, and it must then combine with each kind of address. A second hard case is a refused data byte in the middle of a transfer, which must be followed by more bytes that are ignored. The bench models a bus master with tasks that wait out SCL holding. It places the arbitration pulse right after the START and mixes directed cases with random own addresses, address kinds, acknowledge-enable patterns and endings by STOP or repeated START. Expected codes come from bench functions built on the requirements.

// File: rtl/i2cs_pkg.sv
// Package: shared state type and status code values for the slave receiver.
// Assumes status codes are eight bits wide and fixed by bus convention.
package i2cs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ACKWAIT,
        S_ACKBIT,
        S_DATA,
        S_SKIP
    } rx_state_t;

    localparam logic [7:0] ST_OWN_W       = 8'h60;
    localparam logic [7:0] ST_ARB_OWN_W   = 8'h68;
    localparam logic [7:0] ST_GC_W        = 8'h70;
    localparam logic [7:0] ST_ARB_GC_W    = 8'h78;
    localparam logic [7:0] ST_OWN_DAT_ACK = 8'h80;
    localparam logic [7:0] ST_OWN_DAT_NAK = 8'h88;
    localparam logic [7:0] ST_GC_DAT_ACK  = 8'h90;
    localparam logic [7:0] ST_GC_DAT_NAK  = 8'h98;
    localparam logic [7:0] ST_STOP_RS     = 8'hA0;
    localparam logic [7:0] ST_OWN_R       = 8'hA8;
    localparam logic [7:0] ST_ARB_OWN_R   = 8'hB0;
    localparam logic [7:0] ST_NONE        = 8'hF8;

endpackage

// File: rtl/i2cs_line_watch.sv
// Line watcher: turns the sampled SCL/SDA levels into one-cycle event strobes
// (SCL rise, SCL fall, START, STOP). Assumes the inputs are already
// synchronised to clk and that the bus idles high.
module i2cs_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    // Keep last cycle's line levels for edge detection.
    always_ff @(posedge clk) begin : p_lines
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode edges; SDA moving while SCL stays high is START or STOP.
    always_comb begin : p_decode
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/i2cs_shifter.sv
// Byte shifter: collects BITS serial bits MSB first and flags a full byte.
// Assumes the owner clears it once the full byte has been consumed.
module i2cs_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            shift_i,
    input  logic            bit_i,
    output logic [BITS-1:0] byte_o,
    output logic            full_o
);

    localparam int CNT_W = $clog2(BITS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [BITS-1:0]  sh_q;

    // Shift one bit per strobe until the byte is complete.
    always_ff @(posedge clk) begin : p_shift
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (shift_i && !full_o) begin
            sh_q  <= {sh_q[BITS-2:0], bit_i};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign byte_o = sh_q;
    assign full_o = (cnt_q == CNT_W'(BITS));

    // The bit count never passes the byte length (keeps R4 skipping sane).
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BITS));

endmodule

// File: rtl/i2cs_addr_cmp.sv
// Address comparator: checks a received first byte against the own address
// and, when enabled by bit 0 of the address register, the general call.
// Purely combinational; assumes direction is in bit 0 of the byte.
module i2cs_addr_cmp #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0] rx_byte_i,
    input  logic [ADDR_W:0] own_reg_i,
    output logic            own_hit_o,
    output logic            gc_hit_o,
    output logic            rd_o
);

    // Compare address field and decode direction.
    always_comb begin : p_cmp
        own_hit_o = (rx_byte_i[ADDR_W:1] == own_reg_i[ADDR_W:1]);
        gc_hit_o  = (rx_byte_i[ADDR_W:1] == '0) & own_reg_i[0];
        rd_o      = rx_byte_i[0];
    end

endmodule

// File: rtl/i2c_slave_rx.sv
// I2C slave receiver top: sequences address and data phases, drives the
// acknowledge, posts status codes with an interrupt flag and stretches SCL
// while a byte event is pending. Assumes sampled, synchronised bus lines
// and a single-cycle software clear pulse.
module i2c_slave_rx
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W:0]   own_addr_i,
    input  logic              ctl_en_i,
    input  logic              ctl_ack_en_i,
    input  logic              ctl_sta_i,
    input  logic              ctl_sto_i,
    input  logic              int_clr_i,
    input  logic              arb_lost_i,
    output logic              sda_pull_o,
    output logic              scl_hold_o,
    output logic              int_flag_o,
    output logic [7:0]        status_o,
    output logic [ADDR_W:0]   data_rx_o
);

    localparam int BYTE_W = ADDR_W + 1;

    rx_state_t         st_q;
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] byte_w;
    logic              byte_full, byte_take, shift_en, sh_clr;
    logic              own_hit, gc_hit, rd_dir;
    logic              slave_ok, a_ack, a_gc;
    logic [7:0]        a_code, d_code;
    logic              ack_q, post_q, to_data_q, gc_q, arb_q, rx_mode_q;
    logic [7:0]        pend_q, status_q;
    logic              pull_q, flag_q, hold_q;
    logic [BYTE_W-1:0] data_q;

    i2cs_line_watch u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    assign byte_take = byte_full & ((st_q == S_ADDR) | (st_q == S_DATA));
    assign shift_en  = scl_rise & ((st_q == S_ADDR) | (st_q == S_DATA));
    assign sh_clr    = start_det | byte_take | ~ctl_en_i;

    i2cs_shifter #(.BITS(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (sh_clr),
        .shift_i (shift_en),
        .bit_i   (sda_i),
        .byte_o  (byte_w),
        .full_o  (byte_full)
    );

    i2cs_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .rx_byte_i (byte_w),
        .own_reg_i (own_addr_i),
        .own_hit_o (own_hit),
        .gc_hit_o  (gc_hit),
        .rd_o      (rd_dir)
    );

    // Decide acknowledge and status code for address and data bytes.
    always_comb begin : p_decide
        slave_ok = ctl_en_i & ctl_ack_en_i & ~ctl_sta_i & ~ctl_sto_i;
        a_ack    = slave_ok & (own_hit | (gc_hit & ~rd_dir));
        a_gc     = ~own_hit & gc_hit;
        if (own_hit && !rd_dir)
            a_code = arb_q ? ST_ARB_OWN_W : ST_OWN_W;
        else if (own_hit)
            a_code = arb_q ? ST_ARB_OWN_R : ST_OWN_R;
        else
            a_code = arb_q ? ST_ARB_GC_W : ST_GC_W;
        if (gc_q)
            d_code = slave_ok ? ST_GC_DAT_ACK : ST_GC_DAT_NAK;
        else
            d_code = slave_ok ? ST_OWN_DAT_ACK : ST_OWN_DAT_NAK;
    end

    // Sequence bus phases, drive the acknowledge and post events.
    always_ff @(posedge clk) begin : p_ctrl
        if (!rst_n) begin
            st_q      <= S_IDLE;
            ack_q     <= 1'b0;
            post_q    <= 1'b0;
            to_data_q <= 1'b0;
            gc_q      <= 1'b0;
            arb_q     <= 1'b0;
            rx_mode_q <= 1'b0;
            pend_q    <= ST_NONE;
            status_q  <= ST_NONE;
            pull_q    <= 1'b0;
            flag_q    <= 1'b0;
            hold_q    <= 1'b0;
            data_q    <= '0;
        end else begin
            if (int_clr_i) begin
                flag_q <= 1'b0;
                hold_q <= 1'b0;
            end
            if (arb_lost_i)
                arb_q <= 1'b1;
            if (!ctl_en_i) begin
                st_q      <= S_IDLE;
                pull_q    <= 1'b0;
                arb_q     <= 1'b0;
                rx_mode_q <= 1'b0;
            end else if (start_det || stop_det) begin
                if (rx_mode_q) begin
                    flag_q   <= 1'b1;
                    status_q <= ST_STOP_RS;
                end
                st_q      <= start_det ? S_ADDR : S_IDLE;
                pull_q    <= 1'b0;
                rx_mode_q <= 1'b0;
                if (stop_det)
                    arb_q <= 1'b0;
            end else begin
                case (st_q)
                    S_ADDR: if (byte_full) begin
                        ack_q     <= a_ack;
                        pend_q    <= a_code;
                        post_q    <= a_ack;
                        to_data_q <= a_ack & ~rd_dir;
                        gc_q      <= a_gc;
                        arb_q     <= 1'b0;
                        st_q      <= S_ACKWAIT;
                    end
                    S_DATA: if (byte_full) begin
                        data_q    <= byte_w;
                        ack_q     <= slave_ok;
                        pend_q    <= d_code;
                        post_q    <= 1'b1;
                        to_data_q <= slave_ok;
                        st_q      <= S_ACKWAIT;
                    end
                    S_ACKWAIT: if (scl_fall) begin
                        pull_q <= ack_q;
                        st_q   <= S_ACKBIT;
                    end
                    S_ACKBIT: if (scl_fall) begin
                        pull_q <= 1'b0;
                        if (post_q) begin
                            flag_q   <= 1'b1;
                            hold_q   <= 1'b1;
                            status_q <= pend_q;
                        end
                        rx_mode_q <= to_data_q;
                        st_q      <= to_data_q ? S_DATA : S_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_o = pull_q;
    assign scl_hold_o = hold_q;
    assign int_flag_o = flag_q;
    assign status_o   = status_q;
    assign data_rx_o  = data_q;

    // R12: the SDA drive only moves while SCL is low (enabled operation).
    assert_pull_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en_i && $past(ctl_en_i) && (pull_q != $past(pull_q))) |-> !scl_i);

    // R11: SCL stretching is only present with a pending flag.
    assert_hold_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> flag_q);

    // R2: a pending flag always carries a real status code.
    assert_flag_has_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |-> (status_q != ST_NONE));

    // R10: disabling the interface releases SDA on the next cycle.
    assert_disable_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en_i |=> !pull_q);

    // R5: the receive register only changes while receiving data.
    assert_data_only_in_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_DATA) |=> $stable(data_q));

endmodule

// File: tb/i2c_slave_rx_tb_top.sv
`timescale 1ns/100ps
module i2c_slave_rx_tb_top;

    localparam int Q     = 4;
    localparam int LIMIT = 180000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_m, sda_m;
    logic [7:0] own_addr;
    logic       en, ack_en, sta, sto, clr, arb;
    logic       sda_pull, scl_hold, int_flag;
    logic [7:0] status, data_rx;
    wire        sda_line = sda_m & ~sda_pull;

    int total = 0;
    int fails = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    i2c_slave_rx dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .own_addr_i   (own_addr),
        .ctl_en_i     (en),
        .ctl_ack_en_i (ack_en),
        .ctl_sta_i    (sta),
        .ctl_sto_i    (sto),
        .int_clr_i    (clr),
        .arb_lost_i   (arb),
        .sda_pull_o   (sda_pull),
        .scl_hold_o   (scl_hold),
        .int_flag_o   (int_flag),
        .status_o     (status),
        .data_rx_o    (data_rx)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == LIMIT) begin
            fails = fails + 1;
            total = total + 1;
            $display("FAIL R1 watchdog: actual %0d cycles, expected fewer", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] f_addr(input logic [7:0] own, input logic [7:0] ab,
                                          input logic arbl, input logic ok);
        if (!ok) return 8'h00;
        if (ab[7:1] == own[7:1]) return ab[0] ? (arbl ? 8'hB0 : 8'hA8) : (arbl ? 8'h68 : 8'h60);
        if (ab[7:1] == 7'd0 && own[0] && !ab[0]) return arbl ? 8'h78 : 8'h70;
        return 8'h00;
    endfunction

    function automatic logic [7:0] f_data(input logic gc, input logic ack);
        if (gc) return ack ? 8'h90 : 8'h98;
        return ack ? 8'h80 : 8'h88;
    endfunction

    task automatic wait_hold();
        while (scl_hold) tick(1);
    endtask

    task automatic pulse_clr();
        clr = 1'b1; tick(1); clr = 1'b0; tick(1);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; tick(Q); wait_hold(); scl_m = 1'b1; tick(Q);
        end
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); wait_hold();
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_n, output logic steady);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); wait_hold();
            scl_m = 1'b1; tick(Q);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(Q); wait_hold();
        scl_m = 1'b1; tick(1);
        ack_n = sda_line;
        tick(Q - 1);
        steady = (sda_line == ack_n);
        scl_m = 1'b0; tick(Q);
    endtask

    // ackmode: 0 all bytes acked, 1 random, 2 first acked then refused
    task automatic run_txn(input logic [7:0] own, input logic [7:0] ab, input logic arbl,
                           input int nbytes, input int ackmode, input logic end_rs);
        logic [7:0] exp_a, d;
        logic       ack_n, steady, addressed, gc, ok, a_en;
        string      tag;
        own_addr = own;
        ok    = en & ack_en & ~sta & ~sto;
        exp_a = f_addr(own, ab, arbl, ok);
        if (exp_a != 0) tag = arbl ? "R7" : (ab[0] ? "R8" : ((exp_a == 8'h70) ? "R3" : "R2"));
        else tag = !ok ? "R10" : ((ab[7:1] == 7'd0) ? "R3" : "R4");
        bus_start();
        if (arbl) begin arb = 1'b1; tick(1); arb = 1'b0; end
        send_byte(ab, ack_n, steady);
        chk("R12 ack level steady", steady, 1);
        if (exp_a != 0) begin
            chk(tag, ack_n, 0);
            chk(tag, int_flag, 1);
            chk(tag, status, exp_a);
            chk("R11 hold set", scl_hold, 1);
            pulse_clr();
            chk("R11 hold cleared", {int_flag, scl_hold}, 0);
        end else begin
            chk(tag, ack_n, 1);
            chk(tag, int_flag, 0);
        end
        sta = 1'b0; sto = 1'b0;
        addressed = (exp_a != 0) && !ab[0];
        gc = (exp_a == 8'h70) || (exp_a == 8'h78);
        for (int k = 0; k < nbytes; k++) begin
            d = 8'($urandom);
            a_en = (ackmode == 0) ? 1'b1 : (ackmode == 2) ? (k == 0) : 1'($urandom % 4 != 0);
            ack_en = a_en;
            send_byte(d, ack_n, steady);
            chk("R12 ack level steady", steady, 1);
            if (addressed) begin
                tag = gc ? "R6" : "R5";
                chk(tag, ack_n, !a_en);
                chk(tag, int_flag, 1);
                chk(tag, status, f_data(gc, a_en));
                chk(tag, data_rx, d);
                pulse_clr();
                if (!a_en) addressed = 1'b0;
            end else begin
                chk("R4 ignored byte ack", ack_n, 1);
                chk("R5 ignored byte flag", int_flag, 0);
            end
        end
        ack_en = 1'b1;
        if (end_rs) begin
            bus_start();
            if (addressed) begin
                chk("R9 rstart flag", int_flag, 1);
                chk("R9 rstart code", status, 8'hA0);
                pulse_clr();
            end
            bus_stop();
            chk("R9 stop after rstart", int_flag, 0);
        end else begin
            bus_stop();
            if (addressed) begin
                chk("R9 stop flag", int_flag, 1);
                chk("R9 stop code", status, 8'hA0);
                chk("R11 no hold on stop", scl_hold, 0);
                pulse_clr();
            end else begin
                chk("R9 no stop event", int_flag, 0);
            end
        end
        tick(Q);
    endtask

    initial begin
        logic [7:0] own, ab;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; own_addr = 8'h54;
        en = 1'b1; ack_en = 1'b1; sta = 1'b0; sto = 1'b0; clr = 1'b0; arb = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 scl_hold", scl_hold, 0);
        chk("R1 flag", int_flag, 0);
        chk("R1 status", status, 8'hF8);
        chk("R1 data", data_rx, 0);

        // Directed corner cases
        run_txn(8'h54, 8'h54, 0, 2, 0, 0);   // R2, R5, R9
        run_txn(8'h54, 8'h54, 0, 3, 2, 0);   // R5 refuse then ignore
        run_txn(8'h54, 8'h00, 0, 1, 0, 0);   // R3 general call disabled
        run_txn(8'h55, 8'h00, 0, 2, 2, 0);   // R3, R6
        run_txn(8'h55, 8'h54, 1, 1, 0, 0);   // R7 0x68
        run_txn(8'h55, 8'h00, 1, 1, 0, 0);   // R7 0x78
        run_txn(8'h55, 8'h55, 1, 0, 0, 0);   // R7 0xB0
        run_txn(8'h54, 8'h55, 0, 0, 0, 0);   // R8 0xA8
        run_txn(8'h54, 8'h54, 0, 1, 0, 1);   // R9 repeated start
        run_txn(8'h54, 8'h3A, 0, 2, 0, 0);   // R4 no match
        ack_en = 1'b0; run_txn(8'h54, 8'h54, 0, 1, 0, 0);   // R10
        sta = 1'b1;    run_txn(8'h54, 8'h54, 0, 1, 0, 0);   // R10
        en = 1'b0;     run_txn(8'h54, 8'h54, 0, 1, 0, 0);   // R10
        en = 1'b1;

        // Random transfers
        for (int t = 0; t < 30; t++) begin
            own = {7'(($urandom % 127) + 1), 1'($urandom)};
            case ($urandom % 3)
                0:       ab = {own[7:1], 1'($urandom)};
                1:       ab = {7'd0, 1'($urandom % 4 == 0)};
                default: ab = 8'($urandom);
            endcase
            ack_en = 1'($urandom % 4 != 0);
            sta    = 1'($urandom % 8 == 0);
            run_txn(own, ab, 1'($urandom % 4 == 0), int'($urandom % 4), 1, 1'($urandom));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule